// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 13-bit virtual word address into a 12-bit physical word address through a small page table. The virtual address has two fields. The upper 3 bits are the page number and the lower 10 bits are the line within the page. Physical memory has four 1K-word frames.

Each of the eight table entries holds a 2-bit frame number and a resident flag. A translation request takes one cycle to look up the entry selected by the page number.

- If the page is resident, the block places the frame number above the unchanged line bits and issues a single-cycle memory read strobe.
- If the page is absent, the block issues no read. It raises a sticky fault flag and records the page number, which a paging controller needs in order to bring the page in.

A controller loads or invalidates entries through a one-entry-per-cycle write port. It clears a pending fault with an acknowledge pulse.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset every entry is non-resident, `mem_rd` and `fault` are 0, and any lookup before the first table write faults.
- R2: A request to a resident page drives `mem_paddr` = {frame[1:0], line[9:0]} (frame in bits 11:10, line in bits 9:0) and pulses `mem_rd` high for exactly the one cycle after the request.
- R3: A request to a non-resident page never raises `mem_rd`. It sets `fault` in the cycle after the request, with `fault_page` equal to the virtual address bits 12:10.
- R4: `fault` and `fault_page` stay unchanged until `fault_ack` is seen. `fault` clears in the cycle after an acknowledge that has no new fault alongside it.
- R5: While a fault is pending, a further faulting request keeps the recorded page. A faulting request in the same cycle as `fault_ack` records the new page, and `fault` stays 1.
- R6: A table write with `tbl_we`=1 stores `tbl_frame` and `tbl_resident` at entry `tbl_page`. Writing `tbl_resident`=0 makes later lookups of that page fault.
- R7: A lookup in the same cycle as a write to the same entry uses the entry value from before the write.
- R8: With `req_valid`=0, `mem_rd` stays 0, `mem_paddr` holds its last value and `fault` changes only through `fault_ack`.
- R9: Take a table with pages 1, 2, 5 and 6 in frames 3, 0, 1 and 2 and all other pages absent. With that table, pages 1, 2, 5 and 6 translate to those frames and pages 0, 3, 4 and 7 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 13 | Virtual address: page [12:10], line [9:0] |
| fault_ack | input | 1 | Clears the held fault |
| tbl_we | input | 1 | Table write enable |
| tbl_page | input | 3 | Table entry to write |
| tbl_frame | input | 2 | Frame number to store |
| tbl_resident | input | 1 | Resident flag to store |
| mem_rd | output | 1 | Memory read strobe, one cycle per hit |
| mem_paddr | output | 12 | Physical address, valid with `mem_rd` and held after it |
| fault | output | 1 | Page fault pending |
| fault_page | output | 3 | Page number of the pending fault |

## Verification
A corrupted table entry shows up at the next lookup of that page, one cycle after the request. It appears as a wrong frame in `mem_paddr` bits 11:10, as a spurious read where a fault was due, or as the reverse. A wrong fault register state appears when an idle stretch or a second faulting request changes `fault_page`, or when `fault` fails to drop in the cycle after an acknowledge. The bench reaches each of these by loading a known table, visiting every page and interleaving faults with acknowledges.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  parameter int PAGE_W  = 3;
  parameter int LINE_W  = 10;
  parameter int FRAME_W = 2;

  localparam int VADDR_W   = PAGE_W + LINE_W;
  localparam int PADDR_W   = FRAME_W + LINE_W;
  localparam int NUM_PAGES = 1 << PAGE_W;

  typedef struct packed {
    logic               resident;
    logic [FRAME_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/pxu_rst_sync.sv
module pxu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pxu_page_table.sv
module pxu_page_table
  import page_xlate_pkg::*;
#(
  parameter int P_W = PAGE_W,
  parameter int N_E = NUM_PAGES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [P_W-1:0] wr_idx,
  input  pte_t           wr_entry,
  input  logic [P_W-1:0] rd_idx,
  output pte_t           rd_entry
);
  pte_t           ent_q [N_E];
  logic [N_E-1:0] ent_en;

  always_comb begin
    for (int i = 0; i < N_E; i++) begin
      ent_en[i] = wr_en && (wr_idx == P_W'(i));
    end
  end

  for (genvar g = 0; g < N_E; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ent_q[g] <= '0;
      else if (ent_en[g]) ent_q[g] <= wr_entry;
    end
  end

  // read before write: combinational read of the stored value
  assign rd_entry = ent_q[rd_idx];

  // R6
  tbl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_idx)] == $past(wr_entry));

  // R1
  initial begin
    #1;
    tbl_reset_clear_chk: assert (rst_n || !rd_entry.resident);
  end
endmodule

// File: rtl/pxu_xlate_core.sv
module pxu_xlate_core
  import page_xlate_pkg::*;
#(
  parameter int P_W = PAGE_W,
  parameter int L_W = LINE_W,
  parameter int F_W = FRAME_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [P_W+L_W-1:0] req_vaddr,
  input  logic             fault_ack,
  input  pte_t             entry,
  output logic [P_W-1:0]   lookup_idx,
  output logic             mem_rd,
  output logic [F_W+L_W-1:0] mem_paddr,
  output logic             fault,
  output logic [P_W-1:0]   fault_page
);
  logic [L_W-1:0]     line;
  logic               hit;
  logic               miss;
  logic               rd_d, rd_q;
  logic [F_W+L_W-1:0] paddr_d, paddr_q;
  logic               paddr_en;
  logic               fault_d, fault_q;
  logic [P_W-1:0]     fpage_d, fpage_q;
  logic               fpage_en;

  assign lookup_idx = req_vaddr[P_W+L_W-1:L_W];
  assign line       = req_vaddr[L_W-1:0];

  always_comb begin
    hit      = req_valid &&  entry.resident;
    miss     = req_valid && !entry.resident;
    rd_d     = hit;
    paddr_en = hit;
    paddr_d  = {entry.frame, line};
    fault_d  = miss || (fault_q && !fault_ack);
    fpage_en = miss && (!fault_q || fault_ack);
    fpage_d  = lookup_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        paddr_q <= '0;
    else if (paddr_en) paddr_q <= paddr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fpage_q <= '0;
    else if (fpage_en) fpage_q <= fpage_d;
  end

  assign mem_rd     = rd_q;
  assign mem_paddr  = paddr_q;
  assign fault      = fault_q;
  assign fault_page = fpage_q;

  // R2
  hit_read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && entry.resident) |=> (mem_rd && mem_paddr[L_W-1:0] == $past(line)));

  // R3
  miss_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !entry.resident) |=> (!mem_rd && fault));

  // R4
  fault_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_ack) |=> (fault && $stable(fault_page)));

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ack && !req_valid) |=> !fault);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_rd && $stable(mem_paddr)));

  // R5
  ack_new_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ack && req_valid && !entry.resident) |=> (fault && fault_page == $past(lookup_idx)));
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import page_xlate_pkg::*;
#(
  parameter int P_W = PAGE_W,
  parameter int L_W = LINE_W,
  parameter int F_W = FRAME_W,
  localparam int VA_W = P_W + L_W,
  localparam int PA_W = F_W + L_W,
  localparam int N_E  = 1 << P_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            fault_ack,
  input  logic            tbl_we,
  input  logic [P_W-1:0]  tbl_page,
  input  logic [F_W-1:0]  tbl_frame,
  input  logic            tbl_resident,
  output logic            mem_rd,
  output logic [PA_W-1:0] mem_paddr,
  output logic            fault,
  output logic [P_W-1:0]  fault_page
);
  logic           rst_n_int;
  logic [P_W-1:0] lookup_idx;
  pte_t           wr_entry;
  pte_t           rd_entry;

  assign wr_entry = '{resident: tbl_resident, frame: tbl_frame};

  pxu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pxu_page_table #(.P_W(P_W), .N_E(N_E)) u_table (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_page),
    .wr_entry (wr_entry),
    .rd_idx   (lookup_idx),
    .rd_entry (rd_entry)
  );

  pxu_xlate_core #(.P_W(P_W), .L_W(L_W), .F_W(F_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .fault_ack  (fault_ack),
    .entry      (rd_entry),
    .lookup_idx (lookup_idx),
    .mem_rd     (mem_rd),
    .mem_paddr  (mem_paddr),
    .fault      (fault),
    .fault_page (fault_page)
  );

  // R3
  rd_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(mem_rd && $rose(fault)));
endmodule

// File: tb/page_xlate_unit_bench.sv
module page_xlate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, fault_ack, tbl_we, tbl_resident;
  logic [12:0] req_vaddr;
  logic [2:0]  tbl_page;
  logic [1:0]  tbl_frame;
  logic        mem_rd, fault;
  logic [11:0] mem_paddr;
  logic [2:0]  fault_page;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  page_xlate_unit u_page_xlate_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .fault_ack(fault_ack), .tbl_we(tbl_we), .tbl_page(tbl_page),
    .tbl_frame(tbl_frame), .tbl_resident(tbl_resident), .mem_rd(mem_rd),
    .mem_paddr(mem_paddr), .fault(fault), .fault_page(fault_page)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  task automatic write_entry(input logic [2:0] pg, input logic [1:0] fr, input logic res);
    @(negedge clk);
    tbl_we = 1; tbl_page = pg; tbl_frame = fr; tbl_resident = res;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic request(input logic [12:0] va);
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_hit(input logic [12:0] va, input logic [1:0] fr, input string req);
    request(va);
    chk(mem_rd === 1'b1, req, mem_rd, 1);
    chk(mem_paddr === {fr, va[9:0]}, req, mem_paddr, {fr, va[9:0]});
    chk(fault === 1'b0, req, fault, 0);
  endtask

  task automatic expect_miss(input logic [12:0] va, input string req);
    request(va);
    chk(mem_rd === 1'b0, req, mem_rd, 0);
    chk(fault === 1'b1, req, fault, 1);
    chk(fault_page === va[12:10], req, fault_page, va[12:10]);
  endtask

  task automatic ack();
    @(negedge clk);
    fault_ack = 1;
    @(negedge clk);
    fault_ack = 0;
    chk(fault === 1'b0, "R4 ack clears", fault, 0);
  endtask

  task automatic t_reset();
    chk(mem_rd === 1'b0, "R1 reset rd", mem_rd, 0);
    chk(fault === 1'b0, "R1 reset fault", fault, 0);
    expect_miss(13'h0005, "R1 lookup before load");
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    chk(fault === 1'b1 && fault_page === 3'd0, "R4 held while idle", fault_page, 0);
    ack();
  endtask

  task automatic t_example_table();
    write_entry(3'd1, 2'd3, 1);
    write_entry(3'd2, 2'd0, 1);
    write_entry(3'd5, 2'd1, 1);
    write_entry(3'd6, 2'd2, 1);
    expect_hit({3'd1, 10'h012}, 2'd3, "R9 page1");
    @(negedge clk);
    chk(mem_rd === 1'b0, "R2 single pulse", mem_rd, 0);
    expect_hit({3'd2, 10'h000}, 2'd0, "R9 page2");
    expect_hit({3'd5, 10'h2A5}, 2'd1, "R9 page5");
    expect_hit({3'd6, 10'h3FF}, 2'd2, "R2 page6 top line");
    for (int p = 0; p < 8; p++) begin
      if (p == 0 || p == 3 || p == 4 || p == 7) begin
        expect_miss({3'(p), 10'h155}, "R9 absent page");
        ack();
      end
    end
  endtask

  task automatic t_idle();
    expect_hit({3'd5, 10'h0F0}, 2'd1, "R2 before idle");
    repeat (4) @(negedge clk);
    chk(mem_rd === 1'b0, "R8 idle rd", mem_rd, 0);
    chk(mem_paddr === 12'h4F0, "R8 paddr held", mem_paddr, 12'h4F0);
    chk(fault === 1'b0, "R8 idle fault", fault, 0);
  endtask

  task automatic t_first_fault_kept();
    expect_miss({3'd0, 10'h001}, "R3 first fault");
    request({3'd4, 10'h002});
    chk(fault_page === 3'd0, "R5 first page kept", fault_page, 0);
    @(negedge clk);
    fault_ack = 1; req_valid = 1; req_vaddr = {3'd7, 10'h003};
    @(negedge clk);
    fault_ack = 0; req_valid = 0;
    chk(fault === 1'b1, "R5 ack with new fault", fault, 1);
    chk(fault_page === 3'd7, "R5 new page taken", fault_page, 7);
    ack();
  endtask

  task automatic t_invalidate();
    write_entry(3'd5, 2'd1, 0);
    expect_miss({3'd5, 10'h010}, "R6 invalidated page");
    ack();
    write_entry(3'd3, 2'd2, 1);
    expect_hit({3'd3, 10'h011}, 2'd2, "R6 loaded page");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    tbl_we = 1; tbl_page = 3'd4; tbl_frame = 2'd1; tbl_resident = 1;
    req_valid = 1; req_vaddr = {3'd4, 10'h0AA};
    @(negedge clk);
    tbl_we = 0; req_valid = 0;
    chk(fault === 1'b1 && mem_rd === 1'b0, "R7 old value used", fault, 1);
    ack();
    expect_hit({3'd4, 10'h0AA}, 2'd1, "R7 new value after");
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_vaddr = '0; fault_ack = 0;
    tbl_we = 0; tbl_page = '0; tbl_frame = '0; tbl_resident = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hold();
    t_example_table();
    t_idle();
    t_first_fault_kept();
    t_invalidate();
    t_same_cycle();
    finish_run();
  end
endmodule